// File: doc/BRIEF.md
# Codec Control-Port SPI Slave Model

This block stands in for the control port of an audio codec, so that a host-side sequencer can be exercised against a realistic target. It sits on a system clock and oversamples the four SPI pins. It stays silent until chip-select has gone low and back high a fixed number of times. From then on it treats every chip-select low window as one transaction: a header byte, a 16-bit register address and one data byte. All fields are sent MSB first. The slave samples MOSI on SCLK rising edges and drives MISO on falling edges, so the SCLK line idles high (SPI mode 3).

Registers live in a small page at the bottom of the 0x4000 address range. Bit 0 of the register at 0x4000 acts as the core clock enable. Until that bit is set, only 0x4000 and 0x4002 respond. Reads of any other register return zero, and writes to them are dropped. Two debug outputs show whether SPI mode has been entered and whether the core is enabled.

Top module: `codec_spi_slave`

## Requirements
- R1: Until SPI mode is entered, the slave keeps MISO undriven (`spi_miso_oe_o` = 0) and performs no register write, even when a complete write frame is clocked in.
- R2: `spi_mode_o` goes high after the chip-select line has completed MODE_PULSES low pulses (default 3). The frame that forms the last pulse is still ignored. The flag stays high until reset.
- R3: A frame is 8 header bits, then 16 address bits, then 8 data bits, each field MSB first. Header bit 0 selects the direction (0 = write, 1 = read), and the other header bits have no effect.
- R4: Addresses 0x4000 and 0x4002 can be written and read at any time. `core_en_o` always equals bit 0 of register 0x4000.
- R5: While `core_en_o` is 0, a read of any other address drives MISO low for all eight data bits, and a write to it leaves the register unchanged.
- R6: After reset, register 0x402D holds 0xAA and every other register holds 0x00.
- R7: MISO changes only after SCLK falling edges. While SCLK is high in the data phase, MISO holds steady, and the first data bit is valid before the 25th rising edge.
- R8: While chip-select is high, `spi_miso_oe_o` = 0 and `spi_miso_o` = 1. Each new chip-select low window restarts the bit count, so frames can follow each other back to back.
- R9: Addresses outside 0x4000 .. 0x4000+NUM_REGS-1 read 0x00 and ignore writes. They never alias onto implemented registers.
- R10: If chip-select rises before the 32nd bit has been sampled, the frame is dropped and no register changes.
- R11: Bits after the 32nd in one frame are ignored. There is no address auto-increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| spi_cs_ni | input | 1 | Chip-select, active low |
| spi_sclk_i | input | 1 | Serial clock, idles high |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host, high when not driven |
| spi_miso_oe_o | output | 1 | MISO output enable |
| spi_mode_o | output | 1 | Debug: SPI mode entered |
| core_en_o | output | 1 | Debug: core clock enable (bit 0 of 0x4000) |

## Verification
The bench builds the slave with NUM_REGS = 48, MODE_PULSES = 3 and SYNC_STAGES = 2. With 48 registers, the 0xAA register at 0x402D is still inside the page, while 0x4030 to 0x40FF fall outside it. This lets the bench check unimplemented addresses inside the 0x40xx page as well as addresses below and above the page. Three mode pulses let the bench clock a full write frame in as the final pulse and confirm that it has no effect. An SCLK half period of eight system clocks leaves room for the synchronizer and edge-detect latency, so MISO can be checked both just before each rising edge and in the middle of each high phase.

// File: rtl/codec_spi_pkg.sv
package codec_spi_pkg;
  localparam int HDR_W = 8;

  // power-on register content by page offset
  function automatic logic [31:0] reg_reset_val(int off);
    return (off == 32'h2D) ? 32'h0000_00AA : 32'h0;
  endfunction
endpackage

// File: rtl/codec_spi_sync.sv
module codec_spi_sync #(
  parameter int             WIDTH   = 1,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pipe_q[g] <= RST_VAL;
      else if (g == 0) pipe_q[g] <= d_i;
      else             pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/codec_spi_mode_det.sv
module codec_spi_mode_det #(
  parameter int MODE_PULSES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_rise_i,
  output logic mode_o
);
  localparam int PC_W = $clog2(MODE_PULSES + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(MODE_PULSES - 1);

  logic [PC_W-1:0] pulse_cnt_q;
  logic            mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_cnt_q <= '0;
      mode_q      <= 1'b0;
    end else if (cs_rise_i && !mode_q) begin
      if (pulse_cnt_q == PC_LAST) mode_q <= 1'b1;
      else                        pulse_cnt_q <= pulse_cnt_q + 1'b1;
    end
  end

  assign mode_o = mode_q;

  assert_mode_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |=> mode_q);
endmodule

// File: rtl/codec_spi_frame.sv
module codec_spi_frame
  import codec_spi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              cs_s_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_s_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              miso_o
);
  localparam int FRAME_BITS = HDR_W + ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(HDR_W + ADDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_DATA_0    = CNT_W'(HDR_W + ADDR_W);
  localparam logic [CNT_W-1:0] CNT_LAST      = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] rx_q;
  logic [ADDR_W:0]   rx_next;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic [DATA_W-1:0] tx_q;
  logic              miso_q;
  logic              active;

  assign active  = mode_i & ~cs_s_i;
  assign rx_next = {rx_q, mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rx_q    <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      tx_q    <= '0;
      miso_q  <= 1'b0;
    end else if (!active) begin
      cnt_q  <= '0;
      we_q   <= 1'b0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (sclk_rise_i && cnt_q < CNT_FULL) begin
        cnt_q <= cnt_q + 1'b1;
        rx_q  <= rx_next[ADDR_W-1:0];
        if (cnt_q == CNT_ADDR_LAST) begin
          addr_q <= rx_next[ADDR_W-1:0];
          rd_q   <= rx_next[ADDR_W];   // header bit 0
        end
        if (cnt_q == CNT_LAST && !rd_q) begin
          we_q    <= 1'b1;
          wdata_q <= rx_next[DATA_W-1:0];
        end
      end
      if (sclk_fall_i) begin
        if (rd_q && cnt_q == CNT_DATA_0) begin
          miso_q <= rdata_i[DATA_W-1];
          tx_q   <= {rdata_i[DATA_W-2:0], 1'b0};
        end else if (rd_q && cnt_q > CNT_DATA_0 && cnt_q < CNT_FULL) begin
          miso_q <= tx_q[DATA_W-1];
          tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
        end else begin
          miso_q <= 1'b0;
        end
      end
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign we_o    = we_q;
  assign miso_o  = miso_q;

  assert_no_write_premode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> !we_q);
  assert_miso_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !sclk_fall_i) |=> $stable(miso_q));
  assert_idle_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (cnt_q == '0));
  assert_write_full_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> (cnt_q == CNT_FULL));
  assert_single_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
endmodule

// File: rtl/codec_spi_regfile.sv
module codec_spi_regfile
  import codec_spi_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter int                NUM_REGS  = 64,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              core_en_o
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] OFF_CLK  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_ALT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_LIM  = ADDR_W'(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] mem_q;
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic              hit, exempt, allowed;

  assign off     = addr_i - BASE_ADDR;   // below base wraps out of range
  assign hit     = off < OFF_LIM;
  assign idx     = off[IDX_W-1:0];
  assign exempt  = (off == OFF_CLK) || (off == OFF_ALT);
  assign allowed = hit && (core_en_o || exempt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= DATA_W'(reg_reset_val(i));
    end else if (we_i && allowed) begin
      mem_q[idx] <= wdata_i;
    end
  end

  assign core_en_o = mem_q[0][0];
  assign rdata_o   = allowed ? mem_q[idx] : '0;

  assert_locked_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !core_en_o && off != OFF_CLK && off != OFF_ALT) |=> $stable(mem_q));
  assert_unmapped_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i < BASE_ADDR) |=> $stable(mem_q));
endmodule

// File: rtl/codec_spi_slave.sv
module codec_spi_slave #(
  parameter int                NUM_REGS    = 64,
  parameter int                MODE_PULSES = 3,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic spi_cs_ni,
  input  logic spi_sclk_i,
  input  logic spi_mosi_i,
  output logic spi_miso_o,
  output logic spi_miso_oe_o,
  output logic spi_mode_o,
  output logic core_en_o
);
  logic [2:0]        pins_s;
  logic              cs_s, sclk_s, mosi_s;
  logic              cs_d_q, sclk_d_q;
  logic              sclk_rise, sclk_fall, cs_rise;
  logic              mode;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic              we, miso_bit;

  codec_spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_cs_ni, spi_sclk_i, spi_mosi_i}),
    .q_o   (pins_s)
  );
  assign {cs_s, sclk_s, mosi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q   <= 1'b1;
      sclk_d_q <= 1'b1;
    end else begin
      cs_d_q   <= cs_s;
      sclk_d_q <= sclk_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d_q;
  assign sclk_fall = ~sclk_s & sclk_d_q;
  assign cs_rise   = cs_s & ~cs_d_q;

  codec_spi_mode_det #(.MODE_PULSES(MODE_PULSES)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_rise_i(cs_rise),
    .mode_o   (mode)
  );

  codec_spi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .cs_s_i     (cs_s),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .mosi_s_i   (mosi_s),
    .rdata_i    (rdata),
    .addr_o     (addr),
    .wdata_o    (wdata),
    .we_o       (we),
    .miso_o     (miso_bit)
  );

  codec_spi_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr),
    .we_i     (we),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .core_en_o(core_en_o)
  );

  assign spi_miso_oe_o = mode & ~cs_s;
  assign spi_miso_o    = spi_miso_oe_o ? miso_bit : 1'b1;
  assign spi_mode_o    = mode;

  assert_no_drive_premode_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_mode_o |-> (!spi_miso_oe_o && spi_miso_o));
endmodule

// File: tb/codec_spi_slave_tb.sv
module codec_spi_slave_tb;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, mode_dbg, core_en;
  int   tests = 0, fails = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  codec_spi_slave #(.NUM_REGS(48), .MODE_PULSES(3), .SYNC_STAGES(2)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .spi_cs_ni    (cs_n),
    .spi_sclk_i   (sclk),
    .spi_mosi_i   (mosi),
    .spi_miso_o   (miso),
    .spi_miso_oe_o(miso_oe),
    .spi_mode_o   (mode_dbg),
    .core_en_o    (core_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one chip-select window; nbits clocked, rd holds the data-phase bits
  task automatic frame(input logic [7:0] hdr, input logic [15:0] addr, input logic [7:0] wd,
                       input logic [7:0] extra, input int nbits,
                       output logic [7:0] rd, output logic oe_seen, output logic hold_bad);
    logic [39:0] vec;
    logic        pre;
    vec = {hdr, addr, wd, extra};
    rd = '0; oe_seen = 1'b0; hold_bad = 1'b0;
    cs_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = vec[39-i];
      wait_clk(HP);
      pre = miso;
      oe_seen |= miso_oe;
      if (i >= 24 && i < 32) rd = {rd[6:0], pre};
      sclk = 1'b1;
      wait_clk(HP/2);
      if (i >= 24 && i < 32 && miso !== pre) hold_bad = 1'b1;
      wait_clk(HP - HP/2);
    end
    cs_n = 1'b1;
    mosi = 1'b0;
    wait_clk(2*HP);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] r; logic o, h;
    frame(8'h00, a, d, 8'h00, 32, r, o, h);
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
    logic o, h;
    frame(8'h01, a, 8'h00, 8'h00, 32, d, o, h);
  endtask

  task automatic cs_pulse();
    cs_n = 1'b0; wait_clk(2*HP);
    cs_n = 1'b1; wait_clk(2*HP);
  endtask

  task automatic t_reset();
    check("R1 reset oe", miso_oe, 1'b0);
    check("R8 reset miso idle high", miso, 1'b1);
    check("R2 reset mode flag", mode_dbg, 1'b0);
    check("R4 reset core enable", core_en, 1'b0);
  endtask

  task automatic t_mode_entry();
    logic [7:0] r; logic o, h;
    cs_pulse();
    cs_pulse();
    check("R2 mode after two pulses", mode_dbg, 1'b0);
    frame(8'h00, 16'h4000, 8'h01, 8'h00, 32, r, o, h);  // third pulse, ignored
    check("R1 no drive before mode", o, 1'b0);
    check("R1 write ignored before mode", core_en, 1'b0);
    check("R2 mode after three pulses", mode_dbg, 1'b1);
    cs_pulse();
    check("R2 mode flag sticky", mode_dbg, 1'b1);
  endtask

  task automatic t_exempt();
    logic [7:0] r;
    wr(16'h4002, 8'h5A);
    rd_reg(16'h4002, r);
    check("R4 exempt 0x4002 while locked", r, 8'h5A);
    rd_reg(16'h4000, r);
    check("R4 read 0x4000 while locked", r, 8'h00);
  endtask

  task automatic t_locked();
    logic [7:0] r; logic o, h;
    frame(8'h01, 16'h402D, 8'h00, 8'h00, 32, r, o, h);
    check("R5 locked read drives low", r, 8'h00);
    check("R8 oe during frame", o, 1'b1);
    wr(16'h4010, 8'h33);
    wr(16'h4000, 8'h01);
    check("R4 core enable follows bit0", core_en, 1'b1);
    rd_reg(16'h402D, r);
    check("R6 reset value 0x402D", r, 8'hAA);
    rd_reg(16'h4010, r);
    check("R5 locked write discarded", r, 8'h00);
    rd_reg(16'h4000, r);
    check("R4 readback 0x4000", r, 8'h01);
    rd_reg(16'h4002, r);
    check("R6 exempt kept value", r, 8'h5A);
  endtask

  task automatic t_rw();
    logic [7:0] r; logic o, h;
    wr(16'h4010, 8'hC3);
    frame(8'h01, 16'h4010, 8'h00, 8'h00, 32, r, o, h);
    check("R3 write/read 0x4010", r, 8'hC3);
    check("R7 miso stable while sclk high", h, 1'b0);
    frame(8'hFE, 16'h402F, 8'h96, 8'h00, 32, r, o, h);
    frame(8'h81, 16'h402F, 8'h00, 8'h00, 32, r, o, h);
    check("R3 other header bits ignored", r, 8'h96);
    check("R7 hold on second pattern", h, 1'b0);
    rd_reg(16'h4010, r);
    check("R8 back-to-back frames", r, 8'hC3);
    check("R8 idle oe after frame", miso_oe, 1'b0);
    check("R8 idle miso after frame", miso, 1'b1);
  endtask

  task automatic t_unmapped();
    logic [7:0] r;
    wr(16'h4031, 8'h77);
    rd_reg(16'h4031, r);
    check("R9 unimplemented in page", r, 8'h00);
    wr(16'h5000, 8'h00);
    check("R9 no alias onto 0x4000", core_en, 1'b1);
    wr(16'h3FFF, 8'h55);
    rd_reg(16'h3FFF, r);
    check("R9 below page reads zero", r, 8'h00);
    rd_reg(16'h4010, r);
    check("R9 neighbours untouched", r, 8'hC3);
  endtask

  task automatic t_abort();
    logic [7:0] r; logic o, h;
    frame(8'h00, 16'h4010, 8'h11, 8'h00, 31, r, o, h);
    rd_reg(16'h4010, r);
    check("R10 abort at bit 31", r, 8'hC3);
    frame(8'h00, 16'h4000, 8'h00, 8'h00, 20, r, o, h);
    check("R10 abort in address phase", core_en, 1'b1);
  endtask

  task automatic t_burst();
    logic [7:0] r; logic o, h;
    frame(8'h00, 16'h4011, 8'h3C, 8'hEE, 40, r, o, h);
    rd_reg(16'h4011, r);
    check("R11 first byte written", r, 8'h3C);
    rd_reg(16'h4012, r);
    check("R11 no auto-increment", r, 8'h00);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_mode_entry();
    t_exempt();
    t_locked();
    t_rw();
    t_unmapped();
    t_abort();
    t_burst();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule